// File: doc/BRIEF.md
# Odd-Divide Duty-Corrected Clock Divider

This block divides a fast input clock by a programmable ratio. Each output period is built from a high phase and a low phase. Each phase is a whole number of input-clock cycles taken from its own count field. An odd-duty control bit moves the high-to-low transition half an input cycle earlier, onto a falling edge of the input clock. With that bit set, an odd total ratio such as 3 or 5 gives an output that is high for exactly half of its period. A bypass bit passes the input clock straight through.

The counts and the two control bits are written to a holding register on an update strobe. The running divider picks up the held settings only when a new output period begins, so a change never cuts a phase short. The holding register keeps its contents through reset. Software can therefore load a setting while reset is held and have it take effect at the first edge after release. There is no data stream at this block's edge, so every configuration pin is a plain level or strobe with no handshake.

Top module: `odd_duty_clk_div`

## Requirements
- R1: With the odd-duty bit clear and counts H and L (1..255), `clk_out` is high for exactly H input cycles and low for exactly L input cycles, giving a period of H+L cycles.
- R2: A count field of 0 stands for 256 cycles, in both the high and the low field.
- R3: With the odd-duty bit set, the high time is H-0.5 input cycles and the low time is L+0.5 input cycles. The falling edge of `clk_out` lines up with a falling edge of `clk_in`. Counts 2/1 and 3/2 therefore give 50% duty at ratios 3 and 5.
- R4: `cfg_load` high at a rising `clk_in` edge copies the count and control inputs into the holding register. The running period finishes with its old settings, and the held settings first apply from the next rising edge of `clk_out`.
- R5: With the bypass bit in effect, `clk_out` follows `clk_in` (high one half-cycle, low one half-cycle) and the counts have no effect on it.
- R6: Asserting `rst` drives `clk_out` low at once, without waiting for a clock edge. After `rst` is released, the first high phase starts at the first rising `clk_in` edge.
- R7: The holding register is not cleared by `rst`. A strobe seen while `rst` is high is kept, and a reset pulse with no new strobe resumes the last loaded setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_hi | input | CNT_W | High-phase count in input cycles (0 means 2^CNT_W) |
| cfg_lo | input | CNT_W | Low-phase count in input cycles (0 means 2^CNT_W) |
| cfg_odd | input | 1 | Odd-duty correction: shortens high by half a cycle, lengthens low by half |
| cfg_byp | input | 1 | Bypass: output follows the input clock |
| cfg_load | input | 1 | Update strobe, sampled on the rising edge of `clk_in` |
| clk_out | output | 1 | Divided output clock |

## Verification
Every result is an edge time on `clk_out`, so the bench timestamps output edges and expresses high and low times in half input cycles. The first rising edge is due one half-cycle after reset is released on a falling input edge. An odd-corrected fall is due one half-cycle before the rising edge that would otherwise end the high phase. A strobe is held for one input cycle and reaches the output only at the rising `clk_out` edge that closes the current period, which is H+L cycles after the period's own rising edge. The checks compare timestamps against those points and never sample output levels at a rising `clk_in` edge. The reset checks sample on falling input edges or a fixed offset after the reset change.

// File: rtl/odcd_pkg.sv
package odcd_pkg;

  parameter int unsigned CNT_W_DEF = 8;

  // control bits carried next to the two count fields
  typedef struct packed {
    logic odd;
    logic byp;
  } odcd_ctl_t;

endpackage

// File: rtl/odcd_cfg_shadow.sv
module odcd_cfg_shadow
  import odcd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_in,
  input  logic             load,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  odcd_ctl_t        ctl_in,
  output logic [CNT_W-1:0] hi_s,
  output logic [CNT_W-1:0] lo_s,
  output odcd_ctl_t        ctl_s
);

  // deliberately without reset: settings survive a reset pulse
  always_ff @(posedge clk_in) begin
    if (load) begin
      hi_s  <= hi_in;
      lo_s  <= lo_in;
      ctl_s <= ctl_in;
    end
  end

endmodule

// File: rtl/odcd_phase_ctr.sv
module odcd_phase_ctr
  import odcd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  localparam int unsigned CW   = CNT_W + 1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [CNT_W-1:0] hi_s,
  input  logic [CNT_W-1:0] lo_s,
  input  odcd_ctl_t        ctl_s,
  output logic [CW-1:0]    hi_e,
  output logic [CW-1:0]    lo_e,
  output odcd_ctl_t        ctl_a,
  output logic [CW-1:0]    cnt_q,
  output logic             pos_q,
  output logic             hi_tc,
  output logic             fresh_q
);

  logic [CNT_W-1:0] hi_r, lo_r;
  logic [CW:0]      per_m1;
  logic [CW-1:0]    cnt_nx;
  logic             start;

  // a zero field stands for the full 2^CNT_W cycles
  function automatic logic [CW-1:0] widen(input logic [CNT_W-1:0] v);
    return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  assign hi_e   = widen(hi_r);
  assign lo_e   = widen(lo_r);
  assign per_m1 = {1'b0, hi_e} + {1'b0, lo_e} - 1'b1;
  assign start  = fresh_q | ({1'b0, cnt_q} == per_m1);
  assign hi_tc  = (cnt_q == hi_e - 1'b1);
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) begin
      fresh_q <= 1'b1;
      cnt_q   <= '0;
      pos_q   <= 1'b0;
      hi_r    <= '0;
      lo_r    <= '0;
      ctl_a   <= '0;
    end else if (start) begin
      // period boundary: adopt held settings, open the high phase
      fresh_q <= 1'b0;
      hi_r    <= hi_s;
      lo_r    <= lo_s;
      ctl_a   <= ctl_s;
      cnt_q   <= '0;
      pos_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_nx;
      pos_q   <= (cnt_nx < hi_e);
    end
  end

endmodule

// File: rtl/odcd_half_trim.sv
module odcd_half_trim (
  input  logic clk_in,
  input  logic rst,
  input  logic pos_q,
  input  logic hi_tc,
  input  logic odd_a,
  input  logic byp_a,
  input  logic fresh_q,
  output logic kill_q,
  output logic clk_out
);

  logic div_clk;

  // falling-edge register: ends the last high cycle half a cycle early
  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) kill_q <= 1'b0;
    else     kill_q <= odd_a & pos_q & hi_tc;
  end

  assign div_clk = pos_q & ~kill_q;

  always_comb begin
    if (fresh_q)    clk_out = 1'b0;
    else if (byp_a) clk_out = clk_in;
    else            clk_out = div_clk;
  end

endmodule

// File: rtl/odd_duty_clk_div.sv
module odd_duty_clk_div
  import odcd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  localparam int unsigned CW   = CNT_W + 1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic             cfg_odd,
  input  logic             cfg_byp,
  input  logic             cfg_load,
  output logic             clk_out
);

  logic [CNT_W-1:0] hi_s, lo_s;
  odcd_ctl_t        ctl_in, ctl_s, ctl_a;
  logic [CW-1:0]    hi_e, lo_e, cnt_q;
  logic             pos_q, hi_tc, fresh_q, kill_q;

  assign ctl_in = '{odd: cfg_odd, byp: cfg_byp};

  odcd_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk_in (clk_in),
    .load   (cfg_load),
    .hi_in  (cfg_hi),
    .lo_in  (cfg_lo),
    .ctl_in (ctl_in),
    .hi_s   (hi_s),
    .lo_s   (lo_s),
    .ctl_s  (ctl_s)
  );

  odcd_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_in  (clk_in),
    .rst     (rst),
    .hi_s    (hi_s),
    .lo_s    (lo_s),
    .ctl_s   (ctl_s),
    .hi_e    (hi_e),
    .lo_e    (lo_e),
    .ctl_a   (ctl_a),
    .cnt_q   (cnt_q),
    .pos_q   (pos_q),
    .hi_tc   (hi_tc),
    .fresh_q (fresh_q)
  );

  odcd_half_trim u_trim (
    .clk_in  (clk_in),
    .rst     (rst),
    .pos_q   (pos_q),
    .hi_tc   (hi_tc),
    .odd_a   (ctl_a.odd),
    .byp_a   (ctl_a.byp),
    .fresh_q (fresh_q),
    .kill_q  (kill_q),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/odcd_chk.sv
module odcd_chk #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned CW   = CNT_W + 1
) (
  input logic          clk_in,
  input logic          rst,
  input logic [CW-1:0] hi_e,
  input logic [CW-1:0] lo_e,
  input logic [CW-1:0] cnt_q,
  input logic          pos_q,
  input logic          hi_tc,
  input logic          fresh_q,
  input logic          kill_q,
  input logic          odd_now,
  input logic          clk_out
);

  logic [CW:0] per_len;
  assign per_len = {1'b0, hi_e} + {1'b0, lo_e};

  // R1
  cnt_in_period_chk: assert property (@(posedge clk_in) disable iff (rst)
    {1'b0, cnt_q} < per_len);

  // R1
  hi_phase_end_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!fresh_q && hi_tc) |=> !pos_q);

  // R3
  trim_only_odd_chk: assert property (@(posedge clk_in) disable iff (rst)
    kill_q |-> (odd_now && hi_tc && pos_q));

  // R4
  cfg_held_mid_period_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!fresh_q && ({1'b0, cnt_q} != per_len - 1'b1)) |=> ($stable(hi_e) && $stable(lo_e)));

  // R6
  first_high_chk: assert property (@(posedge clk_in) disable iff (rst)
    fresh_q |=> pos_q);

  // R6
  always @(negedge clk_in) begin
    if (rst) begin
      rst_low_chk: assert (!clk_out);
    end
  end

endmodule

bind odd_duty_clk_div odcd_chk #(.CNT_W(CNT_W)) u_odcd_chk (
  .clk_in  (clk_in),
  .rst     (rst),
  .hi_e    (hi_e),
  .lo_e    (lo_e),
  .cnt_q   (cnt_q),
  .pos_q   (pos_q),
  .hi_tc   (hi_tc),
  .fresh_q (fresh_q),
  .kill_q  (kill_q),
  .odd_now (ctl_a.odd),
  .clk_out (clk_out)
);

// File: tb/odd_duty_clk_div_bench.sv
`timescale 1ns/1ps
module odd_duty_clk_div_bench;

  localparam real HALF = 4.0;   // 125 MHz input clock

  logic       clk_in = 1'b0;
  logic       rst    = 1'b1;
  logic [7:0] cfg_hi = 8'd1;
  logic [7:0] cfg_lo = 8'd1;
  logic       cfg_odd = 1'b0;
  logic       cfg_byp = 1'b0;
  logic       cfg_load = 1'b0;
  logic       clk_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #(HALF) clk_in = ~clk_in;

  odd_duty_clk_div u_odd_duty_clk_div (
    .clk_in   (clk_in),
    .rst      (rst),
    .cfg_hi   (cfg_hi),
    .cfg_lo   (cfg_lo),
    .cfg_odd  (cfg_odd),
    .cfg_byp  (cfg_byp),
    .cfg_load (cfg_load),
    .clk_out  (clk_out)
  );

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       odd;
    logic       byp;
    logic [15:0] eh;   // expected high time, half cycles
    logic [15:0] el;   // expected low time, half cycles
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'd1, 1'b0, 1'b0, 16'd4,   16'd2},
    '{8'd2, 8'd1, 1'b1, 1'b0, 16'd3,   16'd3},
    '{8'd3, 8'd3, 1'b0, 1'b0, 16'd6,   16'd6},
    '{8'd3, 8'd3, 1'b1, 1'b0, 16'd5,   16'd7},
    '{8'd1, 8'd1, 1'b0, 1'b0, 16'd2,   16'd2},
    '{8'd1, 8'd1, 1'b1, 1'b0, 16'd1,   16'd3},
    '{8'd5, 8'd2, 1'b1, 1'b0, 16'd9,   16'd5},
    '{8'd3, 8'd2, 1'b1, 1'b0, 16'd5,   16'd5},
    '{8'd4, 8'd5, 1'b1, 1'b0, 16'd7,   16'd11},
    '{8'd0, 8'd1, 1'b0, 1'b0, 16'd512, 16'd2},
    '{8'd4, 8'd0, 1'b1, 1'b0, 16'd7,   16'd513},
    '{8'd1, 8'd4, 1'b0, 1'b1, 16'd1,   16'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int halves(input realtime d);
    return int'(d / HALF);
  endfunction

  // hold reset, strobe settings (unless skip), release on a falling edge
  task automatic reset_and_load(input logic [7:0] h, input logic [7:0] l,
                                input logic o, input logic b, input bit do_load,
                                output realtime t_rel);
    rst = 1'b1;
    @(negedge clk_in);
    if (do_load) begin
      cfg_hi = h; cfg_lo = l; cfg_odd = o; cfg_byp = b;
      cfg_load = 1'b1;
    end
    @(negedge clk_in);
    cfg_load = 1'b0;
    @(negedge clk_in);
    chk("R6 output low in reset", int'(clk_out), 0);
    t_rel = $realtime;
    rst = 1'b0;
  endtask

  task automatic measure(input string req, input int eh, input int el, input realtime t_rel,
                         input bit chk_first);
    realtime t_r, t_f, t_r2;
    @(posedge clk_out); t_r = $realtime;
    if (chk_first) chk("R6 first high one half-cycle after release", halves(t_r - t_rel), 1);
    @(negedge clk_out); t_f = $realtime;
    @(posedge clk_out); t_r2 = $realtime;
    chk({req, " high half-cycles"}, halves(t_f - t_r), eh);
    chk({req, " low half-cycles"},  halves(t_r2 - t_f), el);
  endtask

  initial begin : watchdog
    #(HALF * 2.0 * 150000.0);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    realtime t_rel, t0, t1;
    string   tag;

    // reset state
    repeat (3) @(negedge clk_in);
    chk("R6 reset state", int'(clk_out), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].byp)                              tag = "R5 bypass";
      else if (VECS[i].hi == 0 || VECS[i].lo == 0)  tag = "R2 zero count";
      else if (VECS[i].odd)                         tag = "R3 odd duty";
      else                                          tag = "R1 plain divide";
      reset_and_load(VECS[i].hi, VECS[i].lo, VECS[i].odd, VECS[i].byp, 1'b1, t_rel);
      measure(tag, int'(VECS[i].eh), int'(VECS[i].el), t_rel, 1'b1);
    end

    // R4: update mid-period applies only at the next rising output edge
    reset_and_load(8'd3, 8'd3, 1'b0, 1'b0, 1'b1, t_rel);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_in);
    cfg_hi = 8'd1; cfg_lo = 8'd1; cfg_load = 1'b1;
    @(negedge clk_in);
    cfg_load = 1'b0;
    @(negedge clk_out); t1 = $realtime;
    chk("R4 old high kept", halves(t1 - t0), 6);
    @(posedge clk_out); t1 = $realtime;
    chk("R4 old period kept", halves(t1 - t0), 12);
    @(negedge clk_out); t0 = $realtime;
    chk("R4 new high applied", halves(t0 - t1), 2);

    // R6: asynchronous reset mid high phase
    reset_and_load(8'd3, 8'd3, 1'b0, 1'b0, 1'b1, t_rel);
    @(posedge clk_out);
    #2;
    rst = 1'b1;
    #1;
    chk("R6 async reset drives low", int'(clk_out), 0);

    // R7: a second reset without a strobe resumes held settings
    reset_and_load(8'd2, 8'd1, 1'b1, 1'b0, 1'b1, t_rel);
    measure("R7 loaded in reset", 3, 3, t_rel, 1'b0);
    cfg_hi = 8'd7; cfg_lo = 8'd7; cfg_odd = 1'b0;
    reset_and_load(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, t_rel);
    measure("R7 kept through reset", 3, 3, t_rel, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule